// File: doc/BRIEF.md
# Serial Lane Remapper with Polarity Correction

This block sits between the physical lanes of a multi-lane serial receiver and the logical lane inputs of a deserializer. Each physical lane delivers a word of sampled bits per cycle. A configuration names the physical lane that carries the clock and the physical lane behind each logical data lane. It also gives the number of data lanes in use and a per-lane inversion mask. The block routes the words into logical order and inverts the lanes that need it. It also flags a configuration that cannot be honoured.

The configuration inputs are copied into an active set only on clock edges where `cfg_hold` is high. Routing therefore never changes while traffic is flowing. Lane outputs are registered one cycle after the physical words arrive. While the link is held, and while the active configuration is illegal, every output is driven to zero.

Top module: `lane_remap`

## Requirements
- R1: One cycle after an edge with `cfg_hold` low and no error, `data_lanes` slice i (bits i*LW +: LW) equals the physical word at index `sel[i]`, where `sel[i]` is `cfg_data_sel[i*IDXW +: IDXW]` of the active configuration, for every i below the active lane count.
- R2: Under the same conditions, `clk_lane` equals the physical word at the active clock index.
- R3: Mask bit 0 of `cfg_pol_inv` belongs to the clock lane and bit i+1 to logical data lane i. When polarity is supplied, a mask bit of 1 inverts every bit of that lane's word and a 0 passes it unchanged.
- R4: When `cfg_pol_given` was low at capture, no lane is inverted, whatever the mask holds.
- R5: `lane_vld[i]` is 1 exactly for i below the active lane count. Data lanes at or above the count are zero with `lane_vld` low.
- R6: `cfg_err` is high when two active data lanes select the same physical lane, or when an active data lane selects the clock lane. Indices of unused lanes are ignored.
- R7: `cfg_err` is high when the clock index or an active data index is NPHY or more, or when the lane count exceeds NDATA.
- R8: While `cfg_err` is high, all lane outputs and `lane_vld` are zero.
- R9: The configuration inputs are captured only on edges with `cfg_hold` high. Changes made while it is low have no effect on the outputs.
- R10: One cycle after an edge with `cfg_hold` high, all lane outputs and `lane_vld` are zero.
- R11: After reset the outputs are zero and `cfg_err` is low. The active configuration has lane count 0, clock index 0 and no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Link held; configuration captured while high |
| cfg_lanes | input | CNTW | Number of logical data lanes in use |
| cfg_clk_sel | input | IDXW | Physical index of the clock lane |
| cfg_data_sel | input | NDATA*IDXW | Physical index per logical data lane |
| cfg_pol_given | input | 1 | Inversion mask is supplied |
| cfg_pol_inv | input | NDATA+1 | Inversion mask, clock first then data lanes |
| phy_lanes | input | NPHY*LW | Sampled words, one per physical lane |
| clk_lane | output | LW | Routed clock lane word |
| data_lanes | output | NDATA*LW | Routed data lane words in logical order |
| lane_vld | output | NDATA | Per logical data lane valid |
| cfg_err | output | 1 | Active configuration is illegal |

## Verification
A configuration capture and the routing of a word can fall on the same edge. On that edge the incoming words belong to the old map, while the new map takes effect from the next edge. The bench drops `cfg_hold` at random points while random words keep flowing. It checks that the cycle after the capture edge is blank, that the following edge routes with the new map, and that the error flag reflects the new map from the capture edge on. It also changes the configuration inputs in mid-run with the hold low and checks that routing is unaffected.

// File: rtl/lane_remap.sv
module lane_remap #(
  parameter int NPHY  = 5,
  parameter int NDATA = 4,
  parameter int LW    = 8,
  parameter int IDXW  = 3,
  parameter int CNTW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_hold,
  input  logic [CNTW-1:0]       cfg_lanes,
  input  logic [IDXW-1:0]       cfg_clk_sel,
  input  logic [NDATA*IDXW-1:0] cfg_data_sel,
  input  logic                  cfg_pol_given,
  input  logic [NDATA:0]        cfg_pol_inv,
  input  logic [NPHY*LW-1:0]    phy_lanes,
  output logic [LW-1:0]         clk_lane,
  output logic [NDATA*LW-1:0]   data_lanes,
  output logic [NDATA-1:0]      lane_vld,
  output logic                  cfg_err
);
  localparam logic [IDXW:0]   NPHY_L  = (IDXW+1)'(NPHY);
  localparam logic [CNTW-1:0] NDATA_L = CNTW'(NDATA);

  logic [CNTW-1:0]       a_cnt;
  logic [IDXW-1:0]       a_clk;
  logic [NDATA*IDXW-1:0] a_sel;
  logic                  a_pgiven;
  logic [NDATA:0]        a_pinv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_cnt    <= '0;
      a_clk    <= '0;
      a_sel    <= '0;
      a_pgiven <= 1'b0;
      a_pinv   <= '0;
    end else if (cfg_hold) begin
      a_cnt    <= cfg_lanes;
      a_clk    <= cfg_clk_sel;
      a_sel    <= cfg_data_sel;
      a_pgiven <= cfg_pol_given;
      a_pinv   <= cfg_pol_inv;
    end

  logic [LW-1:0] phy_arr [NPHY];
  for (genvar p = 0; p < NPHY; p++) begin : g_phy
    assign phy_arr[p] = phy_lanes[p*LW +: LW];
  end

  always_comb begin
    cfg_err = (a_cnt > NDATA_L) || ({1'b0, a_clk} >= NPHY_L);
    for (int i = 0; i < NDATA; i++) begin
      if (CNTW'(i) < a_cnt) begin
        if ({1'b0, a_sel[i*IDXW +: IDXW]} >= NPHY_L) cfg_err = 1'b1;
        if (a_sel[i*IDXW +: IDXW] == a_clk) cfg_err = 1'b1;
        for (int j = 0; j < i; j++)
          if (a_sel[j*IDXW +: IDXW] == a_sel[i*IDXW +: IDXW]) cfg_err = 1'b1;
      end
    end
  end

  logic [LW-1:0]       clk_nxt;
  logic [NDATA*LW-1:0] data_nxt;
  logic [NDATA-1:0]    vld_nxt;

  assign clk_nxt = phy_arr[a_clk] ^ {LW{a_pgiven & a_pinv[0]}};

  for (genvar g = 0; g < NDATA; g++) begin : g_lane
    logic use_l;
    assign use_l = CNTW'(g) < a_cnt;
    assign vld_nxt[g] = use_l;
    assign data_nxt[g*LW +: LW] = use_l
        ? (phy_arr[a_sel[g*IDXW +: IDXW]] ^ {LW{a_pgiven & a_pinv[g+1]}})
        : '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_lane   <= '0;
      data_lanes <= '0;
      lane_vld   <= '0;
    end else if (cfg_hold || cfg_err) begin
      clk_lane   <= '0;
      data_lanes <= '0;
      lane_vld   <= '0;
    end else begin
      clk_lane   <= clk_nxt;
      data_lanes <= data_nxt;
      lane_vld   <= vld_nxt;
    end
endmodule

module lane_remap_chk #(
  parameter int NDATA = 4,
  parameter int LW    = 8,
  parameter int IDXW  = 3,
  parameter int CNTW  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_hold,
  input logic                  cfg_err,
  input logic [LW-1:0]         clk_lane,
  input logic [NDATA*LW-1:0]   data_lanes,
  input logic [NDATA-1:0]      lane_vld,
  input logic [CNTW-1:0]       a_cnt,
  input logic [IDXW-1:0]       a_clk,
  input logic [NDATA*IDXW-1:0] a_sel,
  input logic                  a_pgiven,
  input logic [NDATA:0]        a_pinv
);
  p_hold_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |=> (lane_vld == '0 && data_lanes == '0 && clk_lane == '0));

  p_err_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (lane_vld == '0 && data_lanes == '0 && clk_lane == '0));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hold |=> ($stable(a_cnt) && $stable(a_clk) && $stable(a_sel)
                   && $stable(a_pgiven) && $stable(a_pinv)));

  p_vld_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld & (lane_vld + {{(NDATA-1){1'b0}}, 1'b1})) == '0);

  p_vld_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld != '0) |-> ($countones(lane_vld) == int'(a_cnt)));

  for (genvar g = 0; g < NDATA; g++) begin : g_idle
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_vld[g] |-> (data_lanes[g*LW +: LW] == '0));
  end
endmodule

bind lane_remap lane_remap_chk #(.NDATA(NDATA), .LW(LW), .IDXW(IDXW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_err(cfg_err),
  .clk_lane(clk_lane), .data_lanes(data_lanes), .lane_vld(lane_vld),
  .a_cnt(a_cnt), .a_clk(a_clk), .a_sel(a_sel), .a_pgiven(a_pgiven), .a_pinv(a_pinv)
);

// File: tb/lane_remap_bench.sv
module lane_remap_bench;
  localparam int NPHY = 5, NDATA = 4, LW = 8, IDXW = 3, CNTW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_hold = 1'b0;
  logic [CNTW-1:0] cfg_lanes = '0;
  logic [IDXW-1:0] cfg_clk_sel = '0;
  logic [NDATA*IDXW-1:0] cfg_data_sel = '0;
  logic cfg_pol_given = 1'b0;
  logic [NDATA:0] cfg_pol_inv = '0;
  logic [NPHY*LW-1:0] phy_lanes = '0;
  logic [LW-1:0] clk_lane;
  logic [NDATA*LW-1:0] data_lanes;
  logic [NDATA-1:0] lane_vld;
  logic cfg_err;

  always #2 clk = ~clk;

  lane_remap #(.NPHY(NPHY), .NDATA(NDATA), .LW(LW), .IDXW(IDXW), .CNTW(CNTW)) u_lane_remap (.*);

  int checks = 0, fails = 0;
  int m_cnt = 0, m_clk = 0, m_sel [NDATA] = '{default: 0};
  bit m_given = 0;
  bit [NDATA:0] m_inv = '0;

  function automatic bit m_err();
    bit b = (m_cnt > NDATA) || (m_clk >= NPHY);
    for (int i = 0; i < NDATA; i++)
      if (i < m_cnt) begin
        if (m_sel[i] >= NPHY || m_sel[i] == m_clk) b = 1;
        for (int j = 0; j < i; j++) if (m_sel[j] == m_sel[i]) b = 1;
      end
    return b;
  endfunction

  function automatic logic [LW-1:0] word(int p);
    return (p < NPHY) ? phy_lanes[p*LW +: LW] : '0;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int cnt, int ck, int s0, int s1, int s2, int s3, bit given, bit [NDATA:0] inv);
    cfg_lanes = CNTW'(cnt);
    cfg_clk_sel = IDXW'(ck);
    cfg_data_sel = {IDXW'(s3), IDXW'(s2), IDXW'(s1), IDXW'(s0)};
    cfg_pol_given = given;
    cfg_pol_inv = inv;
  endtask

  task automatic step(string tag);
    logic [LW-1:0] e_clk;
    logic [NDATA*LW-1:0] e_dat;
    logic [NDATA-1:0] e_vld;
    bit blank = cfg_hold || m_err();
    e_clk = '0; e_dat = '0; e_vld = '0;
    if (!blank) begin
      e_clk = word(m_clk) ^ {LW{m_given & m_inv[0]}};
      for (int i = 0; i < NDATA; i++)
        if (i < m_cnt) begin
          e_vld[i] = 1'b1;
          e_dat[i*LW +: LW] = word(m_sel[i]) ^ {LW{m_given & m_inv[i+1]}};
        end
    end
    @(posedge clk);
    if (cfg_hold) begin
      m_cnt = int'(cfg_lanes); m_clk = int'(cfg_clk_sel);
      for (int i = 0; i < NDATA; i++) m_sel[i] = int'(cfg_data_sel[i*IDXW +: IDXW]);
      m_given = cfg_pol_given; m_inv = cfg_pol_inv;
    end
    #1;
    chk({tag, " clk_lane R2"}, 128'(clk_lane), 128'(e_clk));
    chk({tag, " data R1"}, 128'(data_lanes), 128'(e_dat));
    chk({tag, " vld R5"}, 128'(lane_vld), 128'(e_vld));
    chk({tag, " err R6 R7"}, 128'(cfg_err), 128'(m_err()));
  endtask

  task automatic rand_phy();
    for (int p = 0; p < NPHY; p++) phy_lanes[p*LW +: LW] = LW'($urandom);
  endtask

  task automatic load(string tag);
    cfg_hold = 1'b1; rand_phy(); step({tag, " capture R10"});
    cfg_hold = 1'b0;
  endtask

  task automatic run(string tag, int n, bit poke);
    for (int k = 0; k < n; k++) begin
      rand_phy();
      if (poke && k == n/2)
        set_cfg($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                1'($urandom), (NDATA+1)'($urandom));
      step(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int perm [NPHY];
    void'($urandom(32'h5EED_1A4E));
    #1;
    chk("reset vld R11", 128'(lane_vld), 128'(0));
    chk("reset err R11", 128'(cfg_err), 128'(0));
    chk("reset data R11", 128'(data_lanes), 128'(0));
    #6 rst_n = 1'b1;
    run("after reset R11", 3, 0);

    set_cfg(2, 0, 1, 2, 0, 0, 0, '0);
    load("two lanes"); run("two lanes R1", 4, 0);

    set_cfg(4, 4, 3, 2, 1, 0, 1, 5'b10110);
    load("inverted"); run("polarity R3", 4, 0);

    set_cfg(4, 4, 3, 2, 1, 0, 0, 5'b11111);
    load("no polarity"); run("polarity absent R4", 4, 0);

    set_cfg(2, 0, 1, 2, 1, 0, 1, 5'b00001);
    load("inactive dup"); run("unused index ignored R6", 3, 0);

    set_cfg(3, 0, 1, 2, 2, 0, 0, '0);
    load("dup data"); run("duplicate R6 blank R8", 3, 0);
    set_cfg(2, 3, 1, 3, 0, 0, 0, '0);
    load("dup clock"); run("clock clash R6 R8", 3, 0);
    set_cfg(2, 5, 1, 2, 0, 0, 0, '0);
    load("clk range"); run("clock range R7", 3, 0);
    set_cfg(3, 0, 1, 2, 6, 0, 0, '0);
    load("data range"); run("data range R7", 3, 0);
    set_cfg(5, 0, 1, 2, 3, 4, 0, '0);
    load("count range"); run("count range R7", 3, 0);

    for (int t = 0; t < 300; t++) begin
      for (int p = 0; p < NPHY; p++) perm[p] = p;
      for (int p = NPHY - 1; p > 0; p--) begin
        int r = $urandom_range(0, p);
        int tmp = perm[p];
        perm[p] = perm[r]; perm[r] = tmp;
      end
      if ($urandom_range(0, 4) == 0) perm[$urandom_range(0, 4)] = $urandom_range(0, 7);
      set_cfg($urandom_range(0, NDATA), perm[0], perm[1], perm[2], perm[3], perm[4],
              1'($urandom), (NDATA+1)'($urandom));
      load("random");
      run("random R9", $urandom_range(2, 12), 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule